// File: doc/BRIEF.md
# Flash Program/Erase Status Register

This block keeps the eight-bit status word of a NOR-style flash program/erase engine. It receives one-cycle command strobes from a command decoder: start program, start erase, suspend, resume, clear status and hardware reset. It also receives done, fail and paused indications from the embedded controller that performs the cell work. When an operation starts, the block samples a supply-valid input and a block-locked input. It keeps the busy and suspend state, holds the error flags until they are cleared, and returns start, pause and resume pulses to the controller.

Reads use an active-low strobe. The strobe is the combined chip-enable and output-enable, and it is sampled in the clock domain. On the clock edge that first sees the strobe low, the block captures either the status word or the array data word, and holds that value until the strobe goes high. The status word is returned when the decoder asks for status mode, or when an operation is in progress in the bank being read. All pins are plain control and status lines. There is no back-pressure: each strobe is acted on in the cycle it is seen.

Top module: `fsr_ctrl`

## Requirements
- R1: Status bit 7 is 0 while an operation runs or is pausing, and 1 when idle or suspended. It goes 0 on the edge that accepts a program or erase, and the controller sees `eng_start` for one cycle.
- R2: A suspend during a running operation pulses `eng_pause` and leaves bit 7 at 0 until `ctl_paused`. After that, bit 7 is 1, and bit 6 is 1 for an erase or bit 2 is 1 for a program.
- R3: A resume while suspended pulses `eng_resume`, clears bits 6 and 2, and returns bit 7 to 0.
- R4: If `ctl_done` arrives while pausing, the operation completes and bit 6 stays 0. If neither done nor paused arrives within SUSP_LAT cycles of the suspend, the block enters the suspended state by itself.
- R5: `ctl_done` together with `ctl_fail` sets bit 5 after an erase and bit 4 after a program.
- R6: `vpp_ok` is sampled only when a start is requested. If it is low, bit 3 is set and no operation starts. A change of `vpp_ok` during an operation has no effect.
- R7: If `lock_hit` is high when a start is requested, and `vpp_ok` is high, bit 1 is set and no operation starts.
- R8: Bits 5, 4, 3 and 1 stay set until a clear-status strobe arrives while bit 7 is 1, or until a reset.
- R9: A start requested while any of bits 5, 4, 3 or 1 is set starts nothing. It sets bit 5 for an erase or bit 4 for a program. This check has priority over the supply and lock checks.
- R10: `hw_rst` or `rst_n` low forces the status word to 0x80.
- R11: Bit 0 is 1 when an operation is running or suspended in a bank other than `rd_bank`.
- R12: The value read is captured on the first clock edge at which `rd_n` is low. It stays unchanged, with `rd_valid` at 1, until `rd_n` returns high, and `rd_valid` then falls on the next edge.
- R13: The capture takes the status word, zero-extended, when `status_sel` is 1 or when an operation is running in `rd_bank`. Otherwise it takes `arr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| hw_rst | input | 1 | Hardware reset strobe |
| cmd_prog | input | 1 | Program start strobe |
| cmd_erase | input | 1 | Erase start strobe; wins over cmd_prog |
| cmd_susp | input | 1 | Suspend strobe |
| cmd_resume | input | 1 | Resume strobe |
| cmd_clr | input | 1 | Clear-status strobe |
| cmd_bank | input | BANK_W | Bank targeted by a start |
| vpp_ok | input | 1 | Programming supply valid |
| lock_hit | input | 1 | Target block is locked |
| ctl_done | input | 1 | Controller finished the operation |
| ctl_fail | input | 1 | Verify failed; qualified by ctl_done |
| ctl_paused | input | 1 | Controller has paused |
| eng_start | output | 1 | One-cycle start pulse to the controller |
| eng_erase | output | 1 | Current operation is an erase |
| eng_pause | output | 1 | One-cycle pause request |
| eng_resume | output | 1 | One-cycle resume pulse |
| rd_n | input | 1 | Read strobe, active low |
| rd_bank | input | BANK_W | Bank being read |
| status_sel | input | 1 | Decoder is in status-read mode |
| arr_data | input | DATA_W | Array read data |
| rd_data | output | DATA_W | Captured read value |
| rd_valid | output | 1 | rd_data holds a capture for the current strobe |

## Verification
Program and erase operations are run in three ways: to a clean finish, to a failing finish, and through a suspend. The results show that the suspend flag selects bit 6 or bit 2 by operation kind, and that the fail bit selects bit 5 or bit 4. Suspends are ended in three ways: by a controller pause, by a late done, and by the latency cap. These show that bit 7 stays 0 until the engine has really stopped, and that bit 6 is set only when it has. Starts are refused in three ways: supply low, block locked, and an earlier error pending. These show which error bit each refusal raises, and that each is sticky until cleared. Reads are made from the running bank, from another bank, with and without status mode, and with the operation finishing while the strobe is held low. These separate the routing rule from the capture-and-hold rule.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_PAUSE = 2'd2,
    ST_SUSP  = 2'd3
  } fsr_state_e;

  localparam int SR_READY  = 7;
  localparam int SR_ESUSP  = 6;
  localparam int SR_EFAIL  = 5;
  localparam int SR_PFAIL  = 4;
  localparam int SR_VPP    = 3;
  localparam int SR_PSUSP  = 2;
  localparam int SR_LOCK   = 1;
  localparam int SR_BANK   = 0;
  localparam int SR_W      = 8;
endpackage

// File: rtl/fsr_engine.sv
module fsr_engine
  import fsr_pkg::*;
#(
  parameter int BANK_W   = 2,
  parameter int SUSP_LAT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_rst,
  input  logic              cmd_prog,
  input  logic              cmd_erase,
  input  logic              cmd_susp,
  input  logic              cmd_resume,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic              err_any,
  input  logic              vpp_ok,
  input  logic              lock_hit,
  input  logic              ctl_done,
  input  logic              ctl_fail,
  input  logic              ctl_paused,
  output fsr_state_e        state,
  output logic              op_erase,
  output logic [BANK_W-1:0] op_bank,
  output logic              eng_start,
  output logic              eng_pause,
  output logic              eng_resume,
  output logic              set_pfail,
  output logic              set_efail,
  output logic              set_vpp,
  output logic              set_lock
);
  localparam int CNT_W = $clog2(SUSP_LAT + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SUSP_LAT - 1);

  fsr_state_e       nxt;
  logic [CNT_W-1:0] cnt;
  logic             go, pause_p, resume_p, start_req, kind_erase, fin_fail;

  assign start_req  = (cmd_prog || cmd_erase) && (state == ST_IDLE);
  assign kind_erase = cmd_erase;

  always_comb begin
    nxt       = state;
    go        = 1'b0;
    pause_p   = 1'b0;
    resume_p  = 1'b0;
    set_pfail = 1'b0;
    set_efail = 1'b0;
    set_vpp   = 1'b0;
    set_lock  = 1'b0;
    fin_fail  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start_req) begin
          if (err_any) begin
            set_efail = kind_erase;
            set_pfail = !kind_erase;
          end else if (!vpp_ok) begin
            set_vpp = 1'b1;
          end else if (lock_hit) begin
            set_lock = 1'b1;
          end else begin
            go  = 1'b1;
            nxt = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        if (ctl_done) begin
          fin_fail = ctl_fail;
          nxt      = ST_IDLE;
        end else if (cmd_susp) begin
          pause_p = 1'b1;
          nxt     = ST_PAUSE;
        end
      end
      ST_PAUSE: begin
        if (ctl_done) begin
          fin_fail = ctl_fail;
          nxt      = ST_IDLE;
        end else if (ctl_paused || (cnt == CNT_LAST)) begin
          nxt = ST_SUSP;
        end
      end
      ST_SUSP: begin
        if (cmd_resume) begin
          resume_p = 1'b1;
          nxt      = ST_RUN;
        end
      end
      default: nxt = ST_IDLE;
    endcase
    if (fin_fail) begin
      set_efail = op_erase;
      set_pfail = !op_erase;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      op_erase   <= 1'b0;
      op_bank    <= '0;
      cnt        <= '0;
      eng_start  <= 1'b0;
      eng_pause  <= 1'b0;
      eng_resume <= 1'b0;
    end else if (hw_rst) begin
      state      <= ST_IDLE;
      op_erase   <= 1'b0;
      op_bank    <= '0;
      cnt        <= '0;
      eng_start  <= 1'b0;
      eng_pause  <= 1'b0;
      eng_resume <= 1'b0;
    end else begin
      state      <= nxt;
      eng_start  <= go;
      eng_pause  <= pause_p;
      eng_resume <= resume_p;
      if (go) begin
        op_erase <= kind_erase;
        op_bank  <= cmd_bank;
      end
      if (state == ST_PAUSE) cnt <= cnt + 1'b1;
      else                   cnt <= '0;
    end
  end
endmodule

// File: rtl/fsr_flags.sv
module fsr_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_rst,
  input  logic clr_req,
  input  logic ready,
  input  logic set_efail,
  input  logic set_pfail,
  input  logic set_vpp,
  input  logic set_lock,
  output logic efail,
  output logic pfail,
  output logic vpp_bad,
  output logic locked,
  output logic err_any
);
  logic clr_ok;
  assign clr_ok  = clr_req && ready;
  assign err_any = efail || pfail || vpp_bad || locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      efail   <= 1'b0;
      pfail   <= 1'b0;
      vpp_bad <= 1'b0;
      locked  <= 1'b0;
    end else if (hw_rst) begin
      efail   <= 1'b0;
      pfail   <= 1'b0;
      vpp_bad <= 1'b0;
      locked  <= 1'b0;
    end else begin
      efail   <= set_efail || (efail   && !clr_ok);
      pfail   <= set_pfail || (pfail   && !clr_ok);
      vpp_bad <= set_vpp   || (vpp_bad && !clr_ok);
      locked  <= set_lock  || (locked  && !clr_ok);
    end
  end
endmodule

// File: rtl/fsr_rdport.sv
module fsr_rdport
  import fsr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_n,
  input  logic              route_status,
  input  logic [SR_W-1:0]   status,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  logic rd_n_q, fall;
  assign fall = !rd_n && rd_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_n_q   <= 1'b1;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_n_q   <= rd_n;
      rd_valid <= !rd_n && (fall || rd_valid);
      if (fall) rd_data <= route_status ? DATA_W'(status) : arr_data;
    end
  end
endmodule

// File: rtl/fsr_ctrl.sv
module fsr_ctrl
  import fsr_pkg::*;
#(
  parameter int BANK_W   = 2,
  parameter int DATA_W   = 16,
  parameter int SUSP_LAT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_rst,
  input  logic              cmd_prog,
  input  logic              cmd_erase,
  input  logic              cmd_susp,
  input  logic              cmd_resume,
  input  logic              cmd_clr,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic              vpp_ok,
  input  logic              lock_hit,
  input  logic              ctl_done,
  input  logic              ctl_fail,
  input  logic              ctl_paused,
  output logic              eng_start,
  output logic              eng_erase,
  output logic              eng_pause,
  output logic              eng_resume,
  input  logic              rd_n,
  input  logic [BANK_W-1:0] rd_bank,
  input  logic              status_sel,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  fsr_state_e        state;
  logic [BANK_W-1:0] op_bank;
  logic              set_pfail, set_efail, set_vpp, set_lock;
  logic              efail, pfail, vpp_bad, locked, err_any;
  logic              ready, active, route_status;
  logic [SR_W-1:0]   sr;

  fsr_engine #(.BANK_W(BANK_W), .SUSP_LAT(SUSP_LAT)) u_eng (
    .clk(clk), .rst_n(rst_n), .hw_rst(hw_rst),
    .cmd_prog(cmd_prog), .cmd_erase(cmd_erase), .cmd_susp(cmd_susp),
    .cmd_resume(cmd_resume), .cmd_bank(cmd_bank), .err_any(err_any),
    .vpp_ok(vpp_ok), .lock_hit(lock_hit), .ctl_done(ctl_done),
    .ctl_fail(ctl_fail), .ctl_paused(ctl_paused), .state(state),
    .op_erase(eng_erase), .op_bank(op_bank), .eng_start(eng_start),
    .eng_pause(eng_pause), .eng_resume(eng_resume), .set_pfail(set_pfail),
    .set_efail(set_efail), .set_vpp(set_vpp), .set_lock(set_lock)
  );

  assign active = (state == ST_RUN) || (state == ST_PAUSE);
  assign ready  = !active;

  fsr_flags u_flags (
    .clk(clk), .rst_n(rst_n), .hw_rst(hw_rst), .clr_req(cmd_clr),
    .ready(ready), .set_efail(set_efail), .set_pfail(set_pfail),
    .set_vpp(set_vpp), .set_lock(set_lock), .efail(efail), .pfail(pfail),
    .vpp_bad(vpp_bad), .locked(locked), .err_any(err_any)
  );

  always_comb begin
    sr           = '0;
    sr[SR_READY] = ready;
    sr[SR_ESUSP] = (state == ST_SUSP) && eng_erase;
    sr[SR_EFAIL] = efail;
    sr[SR_PFAIL] = pfail;
    sr[SR_VPP]   = vpp_bad;
    sr[SR_PSUSP] = (state == ST_SUSP) && !eng_erase;
    sr[SR_LOCK]  = locked;
    sr[SR_BANK]  = (state != ST_IDLE) && (rd_bank != op_bank);
  end

  assign route_status = status_sel || (active && (rd_bank == op_bank));

  fsr_rdport #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .route_status(route_status),
    .status(sr), .arr_data(arr_data), .rd_data(rd_data), .rd_valid(rd_valid)
  );
endmodule

// File: rtl/fsr_ctrl_chk.sv
module fsr_ctrl_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hw_rst,
  input logic              cmd_prog,
  input logic              cmd_erase,
  input logic              cmd_clr,
  input logic              eng_start,
  input logic              eng_pause,
  input logic              eng_resume,
  input logic              err_any,
  input logic [7:0]        sr,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data
);
  p_reset_value_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hw_rst |=> (sr == 8'h80));

  p_busy_on_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !sr[7]);

  p_pause_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_pause |-> !sr[7]);

  p_resume_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_resume |-> (!sr[6] && !sr[2] && !sr[7]));

  p_sticky_efail_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sr[5] && !hw_rst && !(cmd_clr && sr[7])) |=> sr[5]);

  p_sticky_pfail_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sr[4] && !hw_rst && !(cmd_clr && sr[7])) |=> sr[4]);

  p_sticky_vpp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sr[3] && !hw_rst && !(cmd_clr && sr[7])) |=> sr[3]);

  p_blocked_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_any && (cmd_prog || cmd_erase)) |=> !eng_start);

  p_read_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(rd_valid)) |-> $stable(rd_data));
endmodule

bind fsr_ctrl fsr_ctrl_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/fsr_ctrl_test.sv
module fsr_ctrl_test;
  localparam int BW  = 2;
  localparam int DW  = 16;
  localparam int LAT = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hw_rst = 0, cmd_prog = 0, cmd_erase = 0, cmd_susp = 0, cmd_resume = 0, cmd_clr = 0;
  logic [BW-1:0] cmd_bank = '0, rd_bank = '0;
  logic vpp_ok = 1, lock_hit = 0, ctl_done = 0, ctl_fail = 0, ctl_paused = 0;
  logic eng_start, eng_erase, eng_pause, eng_resume;
  logic rd_n = 1, status_sel = 0;
  logic [DW-1:0] arr_data = 16'hA5C3;
  logic [DW-1:0] rd_data;
  logic rd_valid;
  int checks = 0, errors = 0;
  logic [DW-1:0] d;

  always #2.5 clk = ~clk;

  fsr_ctrl #(.BANK_W(BW), .DATA_W(DW), .SUSP_LAT(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .hw_rst(hw_rst), .cmd_prog(cmd_prog),
    .cmd_erase(cmd_erase), .cmd_susp(cmd_susp), .cmd_resume(cmd_resume),
    .cmd_clr(cmd_clr), .cmd_bank(cmd_bank), .vpp_ok(vpp_ok),
    .lock_hit(lock_hit), .ctl_done(ctl_done), .ctl_fail(ctl_fail),
    .ctl_paused(ctl_paused), .eng_start(eng_start), .eng_erase(eng_erase),
    .eng_pause(eng_pause), .eng_resume(eng_resume), .rd_n(rd_n),
    .rd_bank(rd_bank), .status_sel(status_sel), .arr_data(arr_data),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Read with the strobe low for one edge; returns the captured word.
  task automatic rd(input logic [BW-1:0] bank, input logic sel, output logic [DW-1:0] q);
    @(negedge clk);
    rd_bank = bank; status_sel = sel; rd_n = 0;
    @(negedge clk);
    q = rd_data;
    chk("R12 valid", {15'd0, rd_valid}, 16'd1);
    rd_n = 1; status_sel = 0;
  endtask

  task automatic stat(input string tag, input logic [7:0] exp);
    logic [DW-1:0] q;
    rd(2'd0, 1'b1, q);
    chk(tag, q, {8'd0, exp});
  endtask

  // Pulse one command; returns the engine pulses seen after the edge.
  task automatic cmd(input int which, input logic [BW-1:0] bank,
                     output logic st, output logic pa, output logic re);
    @(negedge clk);
    cmd_bank = bank;
    case (which)
      0: cmd_prog = 1;
      1: cmd_erase = 1;
      2: cmd_susp = 1;
      3: cmd_resume = 1;
      4: cmd_clr = 1;
      default: hw_rst = 1;
    endcase
    @(negedge clk);
    st = eng_start; pa = eng_pause; re = eng_resume;
    cmd_prog = 0; cmd_erase = 0; cmd_susp = 0; cmd_resume = 0; cmd_clr = 0; hw_rst = 0;
  endtask

  task automatic ctl(input logic done, input logic fail, input logic paused);
    @(negedge clk);
    ctl_done = done; ctl_fail = fail; ctl_paused = paused;
    @(negedge clk);
    ctl_done = 0; ctl_fail = 0; ctl_paused = 0;
  endtask

  task automatic t_reset();
    stat("R10 reset value", 8'h80);
    rd(2'd0, 1'b0, d);
    chk("R13 idle array", d, 16'hA5C3);
  endtask

  task automatic t_program_ok();
    logic st, pa, re;
    cmd(0, 2'd1, st, pa, re);
    chk("R1 start pulse", {15'd0, st}, 16'd1);
    rd(2'd1, 1'b0, d);
    chk("R13 busy bank reads status", d, 16'h0000);
    rd(2'd2, 1'b0, d);
    chk("R13 other bank reads array", d, 16'hA5C3);
    rd(2'd2, 1'b1, d);
    chk("R11 other bank bit0", d, 16'h0001);
    ctl(1, 0, 0);
    stat("R1 ready after done", 8'h80);
  endtask

  task automatic t_program_fail();
    logic st, pa, re;
    cmd(0, 2'd0, st, pa, re);
    ctl(1, 1, 0);
    stat("R5 program fail bit4", 8'h90);
    cmd(1, 2'd0, st, pa, re);
    chk("R9 blocked start", {15'd0, st}, 16'd0);
    stat("R9 erase flagged bit5", 8'hB0);
    cmd(4, 2'd0, st, pa, re);
    stat("R8 clear", 8'h80);
    cmd(1, 2'd0, st, pa, re);
    ctl(1, 1, 0);
    stat("R5 erase fail bit5", 8'hA0);
    cmd(4, 2'd0, st, pa, re);
  endtask

  task automatic t_erase_suspend();
    logic st, pa, re;
    cmd(1, 2'd0, st, pa, re);
    cmd(2, 2'd0, st, pa, re);
    chk("R2 pause pulse", {15'd0, pa}, 16'd1);
    stat("R2 busy until paused", 8'h00);
    ctl(0, 0, 1);
    stat("R2 erase suspended", 8'hC0);
    rd(2'd1, 1'b1, d);
    chk("R11 suspended other bank", d, 16'h00C1);
    cmd(3, 2'd0, st, pa, re);
    chk("R3 resume pulse", {15'd0, re}, 16'd1);
    stat("R3 running again", 8'h00);
    ctl(1, 0, 0);
    stat("R1 done", 8'h80);
  endtask

  task automatic t_program_suspend();
    logic st, pa, re;
    cmd(0, 2'd3, st, pa, re);
    cmd(2, 2'd0, st, pa, re);
    ctl(0, 0, 1);
    rd(2'd3, 1'b1, d);
    chk("R2 program suspended bit2", d, 16'h0084);
    cmd(3, 2'd0, st, pa, re);
    rd(2'd3, 1'b1, d);
    chk("R3 bit2 cleared", d, 16'h0000);
    ctl(1, 0, 0);
  endtask

  task automatic t_late_suspend();
    logic st, pa, re;
    cmd(1, 2'd0, st, pa, re);
    cmd(2, 2'd0, st, pa, re);
    ctl(1, 0, 0);
    stat("R4 completes instead", 8'h80);
    cmd(1, 2'd0, st, pa, re);
    cmd(2, 2'd0, st, pa, re);
    repeat (LAT - 2) @(negedge clk);
    stat("R4 still pausing", 8'h00);
    stat("R4 cap forces suspend", 8'hC0);
    cmd(3, 2'd0, st, pa, re);
    ctl(1, 0, 0);
  endtask

  task automatic t_supply();
    logic st, pa, re;
    vpp_ok = 0;
    cmd(0, 2'd0, st, pa, re);
    chk("R6 no start on low supply", {15'd0, st}, 16'd0);
    stat("R6 bit3", 8'h88);
    vpp_ok = 1;
    cmd(4, 2'd0, st, pa, re);
    stat("R8 clear bit3", 8'h80);
    cmd(0, 2'd0, st, pa, re);
    vpp_ok = 0;
    ctl(1, 0, 0);
    vpp_ok = 1;
    stat("R6 mid-op change ignored", 8'h80);
  endtask

  task automatic t_lock();
    logic st, pa, re;
    lock_hit = 1;
    cmd(1, 2'd0, st, pa, re);
    lock_hit = 0;
    chk("R7 no start when locked", {15'd0, st}, 16'd0);
    stat("R7 bit1", 8'h82);
    stat("R8 bit1 sticky", 8'h82);
    cmd(4, 2'd0, st, pa, re);
    stat("R8 clear bit1", 8'h80);
  endtask

  task automatic t_hwreset();
    logic st, pa, re;
    cmd(1, 2'd0, st, pa, re);
    cmd(5, 2'd0, st, pa, re);
    stat("R10 reset while busy", 8'h80);
    vpp_ok = 0;
    cmd(0, 2'd0, st, pa, re);
    vpp_ok = 1;
    cmd(5, 2'd0, st, pa, re);
    stat("R10 reset clears error", 8'h80);
  endtask

  task automatic t_hold();
    logic st, pa, re;
    cmd(0, 2'd0, st, pa, re);
    @(negedge clk);
    rd_bank = 0; status_sel = 1; rd_n = 0;
    @(negedge clk);
    chk("R12 captured busy", rd_data, 16'h0000);
    ctl_done = 1;
    @(negedge clk);
    ctl_done = 0;
    @(negedge clk);
    chk("R12 held while low", rd_data, 16'h0000);
    chk("R12 valid held", {15'd0, rd_valid}, 16'd1);
    rd_n = 1; status_sel = 0;
    @(negedge clk);
    chk("R12 valid drops", {15'd0, rd_valid}, 16'd0);
    stat("R12 new read sees ready", 8'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_program_ok();
    t_program_fail();
    t_erase_suspend();
    t_program_suspend();
    t_late_suspend();
    t_supply();
    t_lock();
    t_hwreset();
    t_hold();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule